// File: doc/BRIEF.md
# Modular Exponentiation Engine

This block raises a 128-bit base to a 128-bit exponent and reduces the result by a 128-bit modulus. The same operation serves for RSA encryption and decryption. A single strobe hands over the three operands. The engine then works through the exponent from its least significant bit upwards. Each step calls a bit-serial modular multiplier that reduces after every half step, so no intermediate value ever needs more than one bit above the operand width.

The caller drives `start` for one cycle with base, exponent and modulus on the inputs. The engine raises `busy` and ignores further strobes until it finishes. At the end it pulses `done` for one cycle. `result` holds the answer until a later operation completes. The caller must keep base below the modulus and the modulus above 1. Each instance keeps its own operands and multiplier, so several instances can run side by side with no shared state. A system can therefore have one instance encrypting while another decrypts.

Top module: `modexp_engine`

## Requirements
- R1: After reset `busy` and `done` are 0 and `result` is all zeros.
- R2: For any base < modulus and modulus > 1, the completed `result` equals base^exponent mod modulus.
- R3: An exponent of 0 yields `result` = 1, with `done` high 2 cycles after the clock edge that accepts `start`.
- R4: One modular multiplication takes exactly 257 cycles from its launch to its valid product. An exponent of 1 therefore gives `result` = base, with `done` high 259 cycles after the accepting edge.
- R5: The exponent is scanned from bit 0 upwards. The scan ends at the highest set bit, with no squaring after it, so an exponent of 2 (one squaring, then one multiply) finishes with `done` 518 cycles after the accepting edge.
- R6: A `start` that arrives while `busy` is 1 has no effect. The running operation still returns its own result, and no extra `done` pulse follows.
- R7: `done` is high for exactly one cycle. `result` changes only in the cycle where `done` is high, and otherwise keeps its value, including during a later operation.
- R8: `busy` is 1 in the cycle after an accepted `start` and is 0 in the cycle where `done` pulses.
- R9: Two instances started in the same cycle compute their results independently. For example, encrypting 65 with exponent 17 and decrypting 2790 with exponent 2753, both modulo 3233, give 2790 and 65.
- R10: A base of 0 with a nonzero exponent yields 0.
- R11: Moduli just below 2^128 (for example 2^128 - 159) give correct results. The one-bit-wider intermediate sums never overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request that captures the operands when idle |
| base_i | input | 128 | Base, must be below the modulus |
| exp_i | input | 128 | Exponent |
| mod_i | input | 128 | Modulus, must be greater than 1 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 128 | Last completed base^exponent mod modulus |

## Verification
The bench targets exponents 0, 1 and 2 with exact cycle counts. A design that special-cased zero, squared after the top bit or miscounted multiplier steps would miss the 2, 259 or 518 cycle marks or return a wrong value. The bench uses a base of zero and a modulus just below 2^128 with base = modulus - 1. Here a missing carry bit in the reduction would wrap the sum and give a value other than 1 or the reference. A second strobe is sent mid-operation, and two instances run in the same cycles. A design that reloaded its operands while busy, or that shared state between instances, would report the wrong result or an extra `done` pulse. All values are compared against a reference that uses 256-bit integer arithmetic.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

   // Exponent sequencer states
   typedef enum logic [2:0] {
      X_IDLE,
      X_SCAN,
      X_MULW,
      X_SQ,
      X_SQW
   } xstate_t;

   // Serial multiplier states
   typedef enum logic [1:0] {
      M_IDLE,
      M_DBL,
      M_ADD
   } mstate_t;

endpackage

// File: rtl/modexp_condsub.sv
// Conditional subtraction: maps a value in [0, 2m) into [0, m).
module modexp_condsub #(
   parameter int W          = 128,
   parameter bit BORROW_CMP = 1'b1
) (
   input  logic [W:0]   sum_i,
   input  logic [W-1:0] mod_i,
   output logic [W-1:0] red_o
);

   generate
      if (BORROW_CMP) begin : g_borrow
         // Single subtractor; its borrow decides the selection
         logic [W+1:0] diff;
         assign diff  = {1'b0, sum_i} - {2'b00, mod_i};
         assign red_o = diff[W+1] ? sum_i[W-1:0] : diff[W-1:0];
      end else begin : g_compare
         // Separate magnitude compare and subtract
         logic [W:0] diff;
         logic       ge;
         assign ge    = (sum_i >= {1'b0, mod_i});
         assign diff  = sum_i - {1'b0, mod_i};
         assign red_o = ge ? diff[W-1:0] : sum_i[W-1:0];
      end
   endgenerate

endmodule

// File: rtl/modexp_modmul.sv
// Bit-serial interleaved modular multiplier: two cycles per multiplier bit.
module modexp_modmul
   import modexp_pkg::*;
#(
   parameter int W          = 128,
   parameter bit BORROW_CMP = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] m_i,
   output logic         done,
   output logic [W-1:0] p_o
);

   localparam int CW = $clog2(W);

   mstate_t       st_q;
   logic [W-1:0]  acc_q;
   logic [W-1:0]  a_q;
   logic [W-1:0]  b_q;
   logic [W-1:0]  m_q;
   logic [CW-1:0] cnt_q;
   logic          done_q;
   logic [W:0]    sum;
   logic [W-1:0]  red;

   // Doubling step or conditional-add step share one reducer
   always_comb begin
      if (st_q == M_DBL) begin
         sum = {acc_q, 1'b0};
      end else begin
         sum = {1'b0, acc_q} + {1'b0, (b_q[W-1] ? a_q : {W{1'b0}})};
      end
   end

   modexp_condsub #(.W(W), .BORROW_CMP(BORROW_CMP)) u_red (
      .sum_i (sum),
      .mod_i (m_q),
      .red_o (red)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= M_IDLE;
         acc_q  <= '0;
         a_q    <= '0;
         b_q    <= '0;
         m_q    <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            M_IDLE: begin
               if (start) begin
                  a_q   <= a_i;
                  b_q   <= b_i;
                  m_q   <= m_i;
                  acc_q <= '0;
                  cnt_q <= CW'(W - 1);
                  st_q  <= M_DBL;
               end
            end
            M_DBL: begin
               acc_q <= red;
               st_q  <= M_ADD;
            end
            M_ADD: begin
               acc_q <= red;
               b_q   <= {b_q[W-2:0], 1'b0};
               if (cnt_q == '0) begin
                  done_q <= 1'b1;
                  st_q   <= M_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
                  st_q  <= M_DBL;
               end
            end
            default: st_q <= M_IDLE;
         endcase
      end
   end

   assign done = done_q;
   assign p_o  = acc_q;

endmodule

// File: rtl/modexp_ctrl.sv
// Right-to-left square-and-multiply sequencer.
module modexp_ctrl
   import modexp_pkg::*;
#(
   parameter int W         = 128,
   parameter bit FULL_SCAN = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] base_i,
   input  logic [W-1:0] exp_i,
   input  logic [W-1:0] mod_i,
   output logic         mm_start,
   output logic [W-1:0] mm_a,
   output logic [W-1:0] mm_b,
   output logic [W-1:0] mm_m,
   input  logic         mm_done,
   input  logic [W-1:0] mm_p,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] result
);

   localparam int CW = $clog2(W);

   xstate_t      st_q;
   logic [W-1:0] res_q;
   logic [W-1:0] pw_q;
   logic [W-1:0] e_q;
   logic [W-1:0] m_q;
   logic [W-1:0] out_q;
   logic         done_q;
   logic         last_bit;
   logic         load;
   logic         adv;

   assign load = (st_q == X_IDLE) && start;
   assign adv  = (st_q == X_SQW) && mm_done;

   generate
      if (FULL_SCAN) begin : g_full
         // Fixed-length scan over every exponent bit
         logic [CW-1:0] idx_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idx_q <= '0;
            end else if (load) begin
               idx_q <= '0;
            end else if (adv) begin
               idx_q <= idx_q + 1'b1;
            end
         end
         assign last_bit = (idx_q == CW'(W - 1));
      end else begin : g_early
         // Stop once no set bit remains above the current one
         assign last_bit = (e_q[W-1:1] == '0);
      end
   endgenerate

   assign mm_start = ((st_q == X_SCAN) && e_q[0]) || ((st_q == X_SQ) && !last_bit);
   assign mm_a     = (st_q == X_SCAN) ? res_q : pw_q;
   assign mm_b     = pw_q;
   assign mm_m     = m_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= X_IDLE;
         res_q  <= '0;
         pw_q   <= '0;
         e_q    <= '0;
         m_q    <= '0;
         out_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            X_IDLE: begin
               if (start) begin
                  res_q <= W'(1);
                  pw_q  <= base_i;
                  e_q   <= exp_i;
                  m_q   <= mod_i;
                  st_q  <= X_SCAN;
               end
            end
            X_SCAN: st_q <= e_q[0] ? X_MULW : X_SQ;
            X_MULW: begin
               if (mm_done) begin
                  res_q <= mm_p;
                  st_q  <= X_SQ;
               end
            end
            X_SQ: begin
               if (last_bit) begin
                  out_q  <= res_q;
                  done_q <= 1'b1;
                  st_q   <= X_IDLE;
               end else begin
                  st_q <= X_SQW;
               end
            end
            X_SQW: begin
               if (mm_done) begin
                  pw_q <= mm_p;
                  e_q  <= {1'b0, e_q[W-1:1]};
                  st_q <= X_SCAN;
               end
            end
            default: st_q <= X_IDLE;
         endcase
      end
   end

   assign busy   = (st_q != X_IDLE);
   assign done   = done_q;
   assign result = out_q;

endmodule

// File: rtl/modexp_engine.sv
// Top: modular exponentiation engine.
module modexp_engine #(
   parameter int WIDTH      = 128,
   parameter bit FULL_SCAN  = 1'b0,
   parameter bit BORROW_CMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] base_i,
   input  logic [WIDTH-1:0] exp_i,
   input  logic [WIDTH-1:0] mod_i,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] result
);

   generate
      if (WIDTH < 4) begin : g_bad_width
         $error("modexp_engine: WIDTH must be at least 4");
      end
   endgenerate

   logic             mm_start;
   logic [WIDTH-1:0] mm_a;
   logic [WIDTH-1:0] mm_b;
   logic [WIDTH-1:0] mm_m;
   logic             mm_done;
   logic [WIDTH-1:0] mm_p;

   modexp_ctrl #(.W(WIDTH), .FULL_SCAN(FULL_SCAN)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .base_i   (base_i),
      .exp_i    (exp_i),
      .mod_i    (mod_i),
      .mm_start (mm_start),
      .mm_a     (mm_a),
      .mm_b     (mm_b),
      .mm_m     (mm_m),
      .mm_done  (mm_done),
      .mm_p     (mm_p),
      .busy     (busy),
      .done     (done),
      .result   (result)
   );

   modexp_modmul #(.W(WIDTH), .BORROW_CMP(BORROW_CMP)) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .start (mm_start),
      .a_i   (mm_a),
      .b_i   (mm_b),
      .m_i   (mm_m),
      .done  (mm_done),
      .p_o   (mm_p)
   );

endmodule

// File: rtl/modexp_engine_chk.sv
module modexp_engine_chk #(
   parameter int WIDTH = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] result,
   input logic             mm_start,
   input logic             mm_done,
   input logic [WIDTH-1:0] mm_p,
   input logic [WIDTH-1:0] mm_m
);

   localparam int MUL_CYC = 2 * WIDTH + 1;
   localparam int CCW     = $clog2(MUL_CYC + 1);

   logic [CCW-1:0] cyc_q;

   // Cycles since the multiplier was launched
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q <= '0;
      end else if (mm_start) begin
         cyc_q <= CCW'(1);
      end else if (mm_done) begin
         cyc_q <= '0;
      end else if (cyc_q != '0) begin
         cyc_q <= cyc_q + 1'b1;
      end
   end

   // R4: product valid exactly 257 cycles after launch
   p_mul_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mm_done |-> (cyc_q == CCW'(MUL_CYC)));

   // R2: every product is fully reduced
   p_mm_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mm_done |-> (mm_p < mm_m));

   // R7: completion pulse lasts one cycle
   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: result only moves with the completion pulse
   p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);

   // R8: an accepted request makes the engine busy
   p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R8: busy is released in the completion cycle
   p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

bind modexp_engine modexp_engine_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .result   (result),
   .mm_start (mm_start),
   .mm_done  (mm_done),
   .mm_p     (mm_p),
   .mm_m     (mm_m)
);

// File: tb/tb_modexp_engine.sv
`timescale 1ns/1ps
module tb_modexp_engine;

   localparam int W = 128;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] base_i = '0;
   logic [W-1:0] exp_i = '0;
   logic [W-1:0] mod_i = '0;
   logic         busy;
   logic         done;
   logic [W-1:0] result;

   logic         start2 = 1'b0;
   logic [W-1:0] base2 = '0;
   logic [W-1:0] exp2 = '0;
   logic [W-1:0] mod2 = '0;
   logic         busy2;
   logic         done2;
   logic [W-1:0] result2;

   int total = 0;
   int bad = 0;
   int dcnt = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   modexp_engine #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .base_i(base_i),
      .exp_i(exp_i), .mod_i(mod_i), .busy(busy), .done(done), .result(result)
   );

   modexp_engine #(.WIDTH(W)) dut_dec (
      .clk(clk), .rst_n(rst_n), .start(start2), .base_i(base2),
      .exp_i(exp2), .mod_i(mod2), .busy(busy2), .done(done2), .result(result2)
   );

   always @(negedge clk) if (rst_n && done) dcnt++;

   function automatic logic [W-1:0] mulmod(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] m);
      logic [2*W-1:0] t;
      t = ({{W{1'b0}}, a} * {{W{1'b0}}, b}) % {{W{1'b0}}, m};
      return t[W-1:0];
   endfunction

   function automatic logic [W-1:0] powmod(logic [W-1:0] b, logic [W-1:0] e, logic [W-1:0] m);
      logic [W-1:0] r;
      logic [W-1:0] p;
      r = W'(1);
      p = b;
      for (int i = 0; i < W; i++) begin
         if (e[i]) r = mulmod(r, p, m);
         p = mulmod(p, p, m);
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exv);
      end
   endtask

   // Run one operation on dut; n = edges after the accepting edge until done seen
   task automatic go(input logic [W-1:0] b, input logic [W-1:0] e, input logic [W-1:0] m,
                     output logic [W-1:0] r, output int n);
      @(negedge clk);
      base_i = b; exp_i = e; mod_i = m; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n = 0;
      do begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end while (!done && n < 100000);
      r = result;
      @(negedge clk);
      chk(!done, "R7 done width", W'(done), '0);
   endtask

   task automatic t_reset;
      chk(!busy, "R1 busy", W'(busy), '0);
      chk(!done, "R1 done", W'(done), '0);
      chk(result == '0, "R1 result", result, '0);
   endtask

   task automatic t_exp_zero;
      logic [W-1:0] r; int n;
      go(W'(7), '0, W'(11), r, n);
      chk(r == W'(1), "R3 value", r, W'(1));
      chk(n == 2, "R3 latency", W'(n), W'(2));
   endtask

   task automatic t_exp_one;
      logic [W-1:0] r; int n; logic [W-1:0] b, m;
      m = 128'hC3A5_9F01_7E22_4B68_D1F0_0A3C_5566_7789;
      b = 128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321;
      go(b, W'(1), m, r, n);
      chk(r == b, "R4 value", r, b);
      chk(n == 259, "R4 latency", W'(n), W'(259));
   endtask

   task automatic t_exp_two;
      logic [W-1:0] r; int n; logic [W-1:0] b, m;
      m = 128'h8000_0000_0000_0000_0000_0000_0000_0065;
      b = 128'h7FFF_1111_2222_3333_4444_5555_6666_7777;
      go(b, W'(2), m, r, n);
      chk(r == powmod(b, W'(2), m), "R5 value", r, powmod(b, W'(2), m));
      chk(n == 518, "R5 latency", W'(n), W'(518));
   endtask

   task automatic t_base_zero;
      logic [W-1:0] r; int n;
      go('0, W'(13), 128'hF00D_0000_0000_0000_0000_0000_0000_0001, r, n);
      chk(r == '0, "R10 base zero", r, '0);
   endtask

   task automatic t_values;
      logic [W-1:0] r; int n; logic [W-1:0] b, e, m, x;
      go(W'(4), W'(13), W'(497), r, n);
      chk(r == W'(445), "R2 small", r, W'(445));
      m = 128'hE1B2_7C49_0D3F_A856_1E2F_9C0B_7744_3211;
      b = 128'h5A5A_A5A5_0123_4567_89AB_CDEF_1357_9BDF;
      e = W'(20'hB5E3D);
      x = powmod(b, e, m);
      go(b, e, m, r, n);
      chk(r == x, "R2 mid", r, x);
      m = 128'h9D00_0000_0000_0000_0000_0000_0000_0C3B;
      b = 128'h0000_0000_0000_0001_0000_0000_0000_0003;
      e = W'(40'hA3_5C96_F0E1);
      x = powmod(b, e, m);
      go(b, e, m, r, n);
      chk(r == x, "R2 long exp", r, x);
   endtask

   task automatic t_big_mod;
      logic [W-1:0] r; int n; logic [W-1:0] m, x;
      m = {W{1'b1}} - W'(158);
      go(m - W'(1), W'(2), m, r, n);
      chk(r == W'(1), "R11 (m-1)^2", r, W'(1));
      x = powmod(m - W'(2), W'(65537), m);
      go(m - W'(2), W'(65537), m, r, n);
      chk(r == x, "R11 65537", r, x);
   endtask

   task automatic t_busy_ignore;
      logic [W-1:0] b, e, m, x;
      int d0;
      int n;
      m = 128'hB7E1_5162_8AED_2A6A_BF71_5880_9CF4_F3C7;
      b = 128'h2B7E_1516_28AE_D2A6_ABF7_1588_09CF_4F3C;
      e = W'(3);
      x = powmod(b, e, m);
      d0 = dcnt;
      @(negedge clk);
      base_i = b; exp_i = e; mod_i = m; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      base_i = W'(5); exp_i = W'(0); mod_i = W'(7); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done && n < 100000) begin @(negedge clk); n++; end
      chk(result == x, "R6 result kept", result, x);
      repeat (600) @(negedge clk);
      chk(dcnt - d0 == 1, "R6 single done", W'(dcnt - d0), W'(1));
      chk(!busy, "R6 idle after", W'(busy), '0);
   endtask

   task automatic t_hold;
      logic [W-1:0] r, old; int n; bit moved;
      go(W'(3), W'(5), W'(1000), r, n);
      old = result;
      moved = 1'b0;
      repeat (20) begin
         @(negedge clk);
         if (result != old) moved = 1'b1;
      end
      chk(!moved && old == W'(243), "R7 hold idle", result, W'(243));
      base_i = W'(2); exp_i = W'(10); mod_i = W'(1000); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R8 busy rise", W'(busy), W'(1));
      n = 0;
      while (!done && n < 100000) begin
         if (result != old) moved = 1'b1;
         @(negedge clk);
         n++;
      end
      chk(!moved, "R7 hold busy", result, old);
      chk(!busy, "R8 busy fall", W'(busy), '0);
      chk(result == W'(24), "R2 2^10", result, W'(24));
   endtask

   task automatic t_parallel;
      bit g1, g2; int n;
      logic [W-1:0] r1, r2;
      g1 = 1'b0; g2 = 1'b0; n = 0;
      @(negedge clk);
      base_i = W'(65);   exp_i = W'(17);   mod_i = W'(3233); start = 1'b1;
      base2  = W'(2790); exp2  = W'(2753); mod2  = W'(3233); start2 = 1'b1;
      @(negedge clk);
      start = 1'b0; start2 = 1'b0;
      while (!(g1 && g2) && n < 100000) begin
         if (done)  begin g1 = 1'b1; r1 = result;  end
         if (done2) begin g2 = 1'b1; r2 = result2; end
         @(negedge clk);
         n++;
      end
      chk(g1 && r1 == W'(2790), "R9 encrypt", r1, W'(2790));
      chk(g2 && r2 == W'(65), "R9 decrypt", r2, W'(65));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_exp_zero();
      t_exp_one();
      t_exp_two();
      t_base_zero();
      t_values();
      t_big_mod();
      t_busy_ignore();
      t_hold();
      t_parallel();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule